// File: doc/BRIEF.md
# Dual-Port Word Store with Collision Arbitration

This block is a synchronous memory of 1024 words by 8 bits with two fully independent ports, called left and right. Each port has its own enable, write strobe, read strobe, address, write data and registered read data. Both ports may read and write at the same time. When both are enabled on the same address, an arbiter gives the word to the port that got there first. It raises a busy flag toward the other port and holds that port's writes back until the collision is over.

The block is built in one of two variants. A master instance runs the arbiter itself and drives its busy outputs. A slave instance does no arbitration. It takes a busy level per port from outside, for example from a master instance that watches the same addresses, and uses it only to suppress that port's writes. In this variant its busy outputs stay low.

A port "arrives" in the cycle its enable goes high, or in the cycle its address changes while it is enabled. An access that is held with the same address keeps its original arrival time.

Top module: `dpram_arb`

## Requirements
- R1: After reset both read-data outputs and both busy outputs are 0. A port with enable and read strobe high at a clock edge presents, after that edge, the word stored at its address before any write made at the same edge. Otherwise its read data holds its value.
- R2: In the master variant a busy output can be high only if, in the previous cycle, both enables were high with equal addresses. Ports on different addresses never see busy.
- R3: In the master variant, when both ports are enabled on the same address, the port that arrived in an earlier cycle wins and the other becomes the loser. The result is kept while neither port re-arrives, and the two busy outputs are never both high.
- R4: When both ports arrive on a common address in the same cycle, the left port wins.
- R5: A write by the losing port is suppressed in every cycle in which it loses. The winner's write is stored.
- R6: A write request held by the losing port is stored at the first clock edge at which the port no longer loses.
- R7: The busy flag is registered. It rises in the cycle after the collision cycle and falls in the cycle after the addresses stop matching or an enable goes low.
- R8: The losing port's reads are never suppressed.
- R9: A word written through one port at edge t is returned by a read on the other port issued at edge t+1. A read at edge t itself returns the old word.
- R10: In the slave variant both busy outputs stay 0. A high busy input suppresses that port's write in the same cycle and has no effect on its reads.
- R11: In the slave variant, when both ports write one address at the same edge with no busy input high, the left data is stored.
- R12: The master variant ignores its busy inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lEn | input | 1 | Left port enable |
| lWe | input | 1 | Left write strobe |
| lOe | input | 1 | Left read strobe |
| lAddr | input | 10 | Left word address |
| lWdata | input | 8 | Left write data |
| lRdata | output | 8 | Left registered read data |
| lBusyIn | input | 1 | Left external write block (slave variant) |
| lBusyOut | output | 1 | Left busy flag (master variant) |
| rEn | input | 1 | Right port enable |
| rWe | input | 1 | Right write strobe |
| rOe | input | 1 | Right read strobe |
| rAddr | input | 10 | Right word address |
| rWdata | input | 8 | Right write data |
| rRdata | output | 8 | Right registered read data |
| rBusyIn | input | 1 | Right external write block (slave variant) |
| rBusyOut | output | 1 | Right busy flag (master variant) |

## Verification
The bench builds two instances at the default 10-bit address and 8-bit data widths: `dut` with IS_MASTER=1 and `dutSlave` with IS_MASTER=0. Both receive the same port traffic, so each collision pattern is applied to the arbiter and to the externally blocked variant in the same cycle. Random addresses are mostly drawn from four words. This makes same-address collisions, re-arrivals during a collision and simultaneous arrivals frequent, while occasional full-range addresses cover the whole array. Random busy inputs drive the slave's write blocking and check that the master ignores them.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

  // Strobes issued by the control to the storage datapath each cycle
  typedef struct packed {
    logic lWrite;
    logic rWrite;
    logic lRead;
    logic rRead;
  } portStrobe_t;

  // Which port currently owns a contended word
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

endpackage

// File: rtl/dparb_ctrl.sv
module dparb_ctrl
  import dparb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lEn,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyIn,
  input  logic              rEn,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyIn,
  output portStrobe_t       strb,
  output logic              lBusy,
  output logic              rBusy
);

  logic lLose;
  logic rLose;

  generate
    if (IS_MASTER) begin : g_master
      logic              match;
      logic              lNew;
      logic              rNew;
      logic              pLEn;
      logic              pREn;
      logic [ADDR_W-1:0] pLAddr;
      logic [ADDR_W-1:0] pRAddr;
      owner_e            ownerQ;
      owner_e            ownerNext;
      logic              unusedBusyIn;

      assign unusedBusyIn = lBusyIn ^ rBusyIn;

      assign match = lEn && rEn && (lAddr == rAddr);

      // A port arrives when it becomes enabled or moves while enabled
      assign lNew = lEn && (!pLEn || (pLAddr != lAddr));
      assign rNew = rEn && (!pREn || (pRAddr != rAddr));

      always_comb begin
        ownerNext = OWN_NONE;
        if (match) begin
          if (rNew)                   ownerNext = OWN_LEFT;   // right is later, or a tie
          else if (lNew)              ownerNext = OWN_RIGHT;
          else if (ownerQ == OWN_NONE) ownerNext = OWN_LEFT;
          else                        ownerNext = ownerQ;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pLEn   <= 1'b0;
          pREn   <= 1'b0;
          pLAddr <= '0;
          pRAddr <= '0;
          ownerQ <= OWN_NONE;
        end else begin
          pLEn   <= lEn;
          pREn   <= rEn;
          pLAddr <= lAddr;
          pRAddr <= rAddr;
          ownerQ <= ownerNext;
        end
      end

      assign lLose = (ownerNext == OWN_RIGHT);
      assign rLose = (ownerNext == OWN_LEFT);
      assign lBusy = (ownerQ == OWN_RIGHT);
      assign rBusy = (ownerQ == OWN_LEFT);

      p_busy_needs_match_r2: assert property (@(posedge clk) disable iff (!rstN)
        (lBusy || rBusy) |-> $past(match))
        else $error("busy without a prior address match");

      p_single_loser_r3: assert property (@(posedge clk) disable iff (!rstN)
        !(lBusy && rBusy))
        else $error("both ports flagged busy");

      p_hold_owner_r3: assert property (@(posedge clk) disable iff (!rstN)
        (match && !lNew && !rNew) |=> $stable({lBusy, rBusy}))
        else $error("owner changed without a re-arrival");

      p_tie_left_r4: assert property (@(posedge clk) disable iff (!rstN)
        (match && lNew && rNew) |=> (rBusy && !lBusy))
        else $error("simultaneous arrival not given to left");

      p_busy_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
        !match |=> !(lBusy || rBusy))
        else $error("busy held after collision ended");
    end else begin : g_slave
      logic unusedAddr;
      assign unusedAddr = ^{lAddr, rAddr};
      assign lLose = lBusyIn;
      assign rLose = rBusyIn;
      assign lBusy = 1'b0;
      assign rBusy = 1'b0;
    end
  endgenerate

  always_comb begin
    strb.lWrite = lEn && lWe && !lLose;
    strb.rWrite = rEn && rWe && !rLose;
    strb.lRead  = lEn && lOe;
    strb.rRead  = rEn && rOe;
  end

endmodule

// File: rtl/dparb_datapath.sv
module dparb_datapath
  import dparb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic [DATA_W-1:0] rRdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right first so that a same-edge left write to the word prevails
  always_ff @(posedge clk) begin
    if (strb.rWrite) mem[rAddr] <= rWdata;
    if (strb.lWrite) mem[lAddr] <= lWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdata <= '0;
      rRdata <= '0;
    end else begin
      if (strb.lRead) lRdata <= mem[lAddr];
      if (strb.rRead) rRdata <= mem[rAddr];
    end
  end

  p_no_dual_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(IS_MASTER && strb.lWrite && strb.rWrite && (lAddr == rAddr)))
    else $error("both ports wrote a contended word");

endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
  import dparb_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lEn,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              lBusyIn,
  output logic              lBusyOut,
  input  logic              rEn,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata,
  input  logic              rBusyIn,
  output logic              rBusyOut
);

  portStrobe_t strb;

  dparb_ctrl #(
    .ADDR_W   (ADDR_W),
    .IS_MASTER(IS_MASTER)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lEn    (lEn),
    .lWe    (lWe),
    .lOe    (lOe),
    .lAddr  (lAddr),
    .lBusyIn(lBusyIn),
    .rEn    (rEn),
    .rWe    (rWe),
    .rOe    (rOe),
    .rAddr  (rAddr),
    .rBusyIn(rBusyIn),
    .strb   (strb),
    .lBusy  (lBusyOut),
    .rBusy  (rBusyOut)
  );

  dparb_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IS_MASTER(IS_MASTER)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .lAddr (lAddr),
    .lWdata(lWdata),
    .rAddr (rAddr),
    .rWdata(rWdata),
    .lRdata(lRdata),
    .rRdata(rRdata)
  );

endmodule

// File: tb/tb_dpram_arb.sv
module tb_dpram_arb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       lEn, lWe, lOe, rEn, rWe, rOe;
  logic [9:0] lAddr, rAddr;
  logic [7:0] lWdata, rWdata;
  logic       mLBin, mRBin, sLBin, sRBin;
  logic [7:0] mLRd, mRRd, sLRd, sRRd;
  logic       mLBusy, mRBusy, sLBusy, sRBusy;

  int    checks   = 0;
  int    failures = 0;
  string phase    = "reset";

  // Reference state, index 0 = master, 1 = slave
  logic [7:0] refMem [2][1024];
  bit         pLEn [2];
  bit         pREn [2];
  logic [9:0] pLA  [2];
  logic [9:0] pRA  [2];
  int         own  [2];
  logic [7:0] expLRd [2];
  logic [7:0] expRRd [2];
  bit         expLB  [2];
  bit         expRB  [2];

  always #10 clk = ~clk;   // 50 MHz

  dpram_arb #(.IS_MASTER(1'b1)) dut (
    .clk(clk), .rstN(rstN),
    .lEn(lEn), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(mLRd),
    .lBusyIn(mLBin), .lBusyOut(mLBusy),
    .rEn(rEn), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(mRRd),
    .rBusyIn(mRBin), .rBusyOut(mRBusy)
  );

  dpram_arb #(.IS_MASTER(1'b0)) dutSlave (
    .clk(clk), .rstN(rstN),
    .lEn(lEn), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(sLRd),
    .lBusyIn(sLBin), .lBusyOut(sLBusy),
    .rEn(rEn), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(sRRd),
    .rBusyIn(sRBin), .rBusyOut(sRBusy)
  );

  function automatic logic [7:0] initWord(int i);
    return 8'((i * 37 + 1) & 255);
  endfunction

  function automatic bit arrives(bit en, bit pen, logic [9:0] a, logic [9:0] pa);
    return en && (!pen || (a != pa));
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s [%s]: got %0h expected %0h", tag, phase, got, exp);
    end
  endtask

  // Advance the model over one edge, then compare both instances
  task automatic tick();
    for (int k = 0; k < 2; k++) begin
      bit match, lLose, rLose;
      int on;
      match = lEn && rEn && (lAddr == rAddr);
      if (k == 0) begin
        bit ln, rn;
        ln = arrives(lEn, pLEn[k], lAddr, pLA[k]);
        rn = arrives(rEn, pREn[k], rAddr, pRA[k]);
        if (!match)          on = 0;
        else if (rn)         on = 1;
        else if (ln)         on = 2;
        else if (own[k] == 0) on = 1;
        else                 on = own[k];
        lLose = (on == 2);
        rLose = (on == 1);
        own[k] = on;
        expLB[k] = lLose;
        expRB[k] = rLose;
      end else begin
        lLose = sLBin;
        rLose = sRBin;
        expLB[k] = 1'b0;
        expRB[k] = 1'b0;
      end
      if (lEn && lOe) expLRd[k] = refMem[k][lAddr];
      if (rEn && rOe) expRRd[k] = refMem[k][rAddr];
      if (rEn && rWe && !rLose) refMem[k][rAddr] = rWdata;
      if (lEn && lWe && !lLose) refMem[k][lAddr] = lWdata;
      pLEn[k] = lEn; pREn[k] = rEn; pLA[k] = lAddr; pRA[k] = rAddr;
    end
    @(posedge clk);
    #1;
    chk("R3 master left busy", 32'(mLBusy), 32'(expLB[0]));
    chk("R3 master right busy", 32'(mRBusy), 32'(expRB[0]));
    chk("R10 slave left busy", 32'(sLBusy), 32'(expLB[1]));
    chk("R10 slave right busy", 32'(sRBusy), 32'(expRB[1]));
    chk("R1 master left rdata", 32'(mLRd), 32'(expLRd[0]));
    chk("R1 master right rdata", 32'(mRRd), 32'(expRRd[0]));
    chk("R1 slave left rdata", 32'(sLRd), 32'(expLRd[1]));
    chk("R1 slave right rdata", 32'(sRRd), 32'(expRRd[1]));
  endtask

  task automatic setL(bit en, bit we, bit oe, int a, logic [7:0] d);
    lEn = en; lWe = we; lOe = oe; lAddr = 10'(a); lWdata = d;
  endtask

  task automatic setR(bit en, bit we, bit oe, int a, logic [7:0] d);
    rEn = en; rWe = we; rOe = oe; rAddr = 10'(a); rWdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_2024);
    rstN = 1'b0;
    setL(0, 0, 0, 0, 8'h00);
    setR(0, 0, 0, 0, 8'h00);
    mLBin = 0; mRBin = 0; sLBin = 0; sRBin = 0;
    for (int k = 0; k < 2; k++) begin
      pLEn[k] = 0; pREn[k] = 0; pLA[k] = '0; pRA[k] = '0; own[k] = 0;
      expLRd[k] = '0; expRRd[k] = '0; expLB[k] = 0; expRB[k] = 0;
      for (int i = 0; i < 1024; i++) refMem[k][i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset lRdata", 32'(mLRd), 0);
    chk("R1 reset rRdata", 32'(mRRd), 0);
    chk("R1 reset busy", 32'({mLBusy, mRBusy, sLBusy, sRBusy}), 0);
    rstN = 1'b1;

    phase = "fill";
    for (int i = 0; i < 1024; i++) begin
      setL(1, 1, 0, i, initWord(i));
      tick();
    end
    setL(0, 0, 0, 0, 0);
    tick();

    // Left arrives first on word 5, right writes later
    phase = "R3 left first";
    setL(1, 0, 1, 5, 8'h00);
    tick();
    setR(1, 1, 1, 5, 8'hAA);
    tick();
    chk("R7 busy rises after collision", 32'(mRBusy), 1);
    chk("R8 loser read returned", 32'(mRRd), 32'(initWord(5)));
    tick();
    chk("R5 loser write suppressed", 32'(mLRd), 32'(initWord(5)));
    setL(0, 0, 0, 0, 8'h00);
    tick();
    chk("R7 busy falls after collision", 32'(mRBusy), 0);
    setR(1, 0, 1, 5, 8'h00);
    tick();
    chk("R6 held write completed", 32'(mRRd), 32'hAA);

    // Same-cycle arrival on word 9
    phase = "R4 tie";
    setL(0, 0, 0, 0, 8'h00);
    setR(0, 0, 0, 0, 8'h00);
    tick();
    setL(1, 1, 0, 9, 8'h11);
    setR(1, 1, 0, 9, 8'h22);
    tick();
    chk("R4 right loses tie", 32'({mLBusy, mRBusy}), 32'b01);
    setL(0, 0, 0, 0, 8'h00);
    setR(1, 0, 1, 9, 8'h00);
    tick();
    chk("R5 winner data stored", 32'(mRRd), 32'h11);
    chk("R11 slave left write prevails", 32'(sRRd), 32'h11);

    // Cross-port visibility on word 20
    phase = "R9 cross port";
    setL(1, 1, 0, 20, 8'h5A);
    setR(1, 0, 1, 20, 8'h00);
    tick();
    chk("R9 same-edge read is old", 32'(mRRd), 32'(initWord(20)));
    setL(0, 0, 0, 0, 8'h00);
    tick();
    chk("R9 next read sees new word", 32'(mRRd), 32'h5A);

    // Different addresses
    phase = "R2 no match";
    setL(1, 0, 1, 30, 8'h00);
    setR(1, 0, 1, 31, 8'h00);
    tick();
    tick();
    chk("R2 no busy on distinct words", 32'({mLBusy, mRBusy}), 0);

    // Right arrives first on word 40
    phase = "R3 right first";
    setL(0, 0, 0, 0, 8'h00);
    setR(1, 0, 1, 40, 8'h00);
    tick();
    setL(1, 1, 1, 40, 8'h77);
    tick();
    chk("R3 later left loses", 32'({mLBusy, mRBusy}), 32'b10);

    // External blocking on the slave, ignored by the master
    phase = "R10 slave block";
    setL(0, 0, 0, 0, 8'h00);
    setR(0, 0, 0, 0, 8'h00);
    tick();
    sLBin = 1; mLBin = 1;
    setL(1, 1, 0, 50, 8'h99);
    tick();
    sLBin = 0; mLBin = 0;
    setL(1, 0, 1, 50, 8'h00);
    tick();
    chk("R10 slave write blocked", 32'(sLRd), 32'(initWord(50)));
    chk("R10 slave busy out low", 32'({sLBusy, sRBusy}), 0);
    chk("R12 master ignores busy input", 32'(mLRd), 32'h99);

    // Random traffic over a small address window
    phase = "random";
    for (int n = 0; n < 4000; n++) begin
      bit wide;
      wide = ($urandom % 8) == 0;
      setL(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
           wide ? int'($urandom % 1024) : int'($urandom % 4), 8'($urandom));
      wide = ($urandom % 8) == 0;
      setR(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
           wide ? int'($urandom % 1024) : int'($urandom % 4), 8'($urandom));
      sLBin = ($urandom % 4) == 0;
      sRBin = ($urandom % 4) == 0;
      mLBin = $urandom % 2;
      mRBin = $urandom % 2;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule